// File: doc/BRIEF.md
# Start-of-Frame Watchdog with Frame Counter

This block keeps a USB device's notion of frame time alive. Each received start-of-frame marker arrives as a one-cycle pulse carrying an 11-bit frame number. The block turns each one into a frame-start strobe and loads the frame number from it. It also times the gap to the next marker. If that gap grows past the nominal frame length plus a small tolerance, the block treats the marker as lost. It then produces a substitute frame event of its own, so that consumers such as isochronous bank swapping keep their rhythm.

A substitute event looks the same as a real one to downstream logic: the same strobe fires, the same sticky interrupt flag is set, and the frame number moves on by one. A separate indicator marks which events were substituted. The watchdog arms only after the first genuine marker following a chip reset or a bus reset, so an unconnected or resetting bus produces no events. Software clears the flag by writing one, and an enable input gates the flag onto the interrupt line.

Top module: `sof_watchdog`

## Requirements
- R1: After a synchronous reset, `frame_strobe_o`, `synth_o`, `sof_flag_o` and `irq_o` are 0 and `fnum_o` is 0.
- R2: After reset or bus reset, no frame event of any kind occurs until a real marker has been received, however long the bus stays silent.
- R3: A real marker sampled on a clock edge raises `frame_strobe_o` for exactly one cycle after that edge, with `synth_o` low and `fnum_o` equal to the marker's frame number.
- R4: Once armed, if no real marker arrives for LIMIT = FRAME_CYCLES + TOL_CYCLES cycles after the last event, a substitute event is output exactly LIMIT cycles after the previous event's strobe, with `synth_o` high for that one cycle. Substitutes then repeat every LIMIT cycles.
- R5: Each substitute event sets `fnum_o` to its previous value plus one.
- R6: The frame number is 11 bits wide and a substitute event at 2047 produces 0.
- R7: A real marker restarts the interval timer. A real marker that arrives on the very edge on which a substitute would fire takes its place: the frame number is loaded rather than incremented, and `synth_o` stays low.
- R8: Every frame event, real or substitute, sets `sof_flag_o` on the same edge that raises `frame_strobe_o`.
- R9: A pulse on `irq_clr_i` clears `sof_flag_o` on the next edge, unless a frame event occurs on that same edge, in which case the flag stays set.
- R10: `irq_o` equals `sof_flag_o` while `irq_en_i` is 1 and is 0 while `irq_en_i` is 0.
- R11: A pulse on `bus_reset_i` disarms the watchdog and sets `fnum_o` to 0. A marker sampled together with the bus reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset seen on the line; disarms the watchdog |
| sof_valid_i | input | 1 | One-cycle pulse: start-of-frame marker received |
| sof_fnum_i | input | 11 | Frame number carried by the marker |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| irq_en_i | input | 1 | Interrupt enable |
| frame_strobe_o | output | 1 | One-cycle frame-start strobe (real or substitute) |
| synth_o | output | 1 | High with the strobe when the event was substituted |
| sof_flag_o | output | 1 | Sticky start-of-frame flag |
| irq_o | output | 1 | Flag gated by the enable |
| fnum_o | output | 11 | Current frame number |

## Verification
Two pairs of functions can land on one clock edge, and both are forced on purpose. The first pair is a real marker and the timeout. The bench counts cycles from the last strobe and drives a marker so that it is sampled on exactly the edge where a substitute is due. The scoreboard then requires a single strobe at that cycle, carrying the loaded number with the substitute indicator low. The second pair is a flag clear and a frame event. The clear pulse is placed on the edge of a predicted substitute event, and the flag must read set afterwards.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int FN_W = 11;
  typedef logic [FN_W-1:0] fnum_t;
endpackage

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int FRAME_CYCLES = 125000,
  parameter int TOL_CYCLES   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic sof_valid_i,
  output logic tick_o,
  output logic armed_o
);
  localparam int LIMIT = FRAME_CYCLES + TOL_CYCLES;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // Counts cycles since the last event, real or substitute
  always_ff @(posedge clk) begin
    if (rst || bus_reset_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sof_valid_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o  = armed_q && !sof_valid_i && !bus_reset_i && (cnt_q == LAST);
  assign armed_o = armed_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
  AST_IDLE_AFTER_BUS_RESET: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> !tick_o); // R2
  AST_UNARMED_STILL: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !sof_valid_i) |=> cnt_q == '0); // R2
endmodule

// File: rtl/sof_fnum_reg.sv
module sof_fnum_reg
  import sof_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear_i,
  input  logic  load_i,
  input  fnum_t load_val_i,
  input  logic  incr_i,
  output fnum_t fnum_o
);
  fnum_t fnum_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  fnum_q <= '0;
    else if (load_i)     fnum_q <= load_val_i;
    else if (incr_i)     fnum_q <= fnum_q + 1'b1; // natural wrap 2047 -> 0
  end

  assign fnum_o = fnum_q;

  AST_LOAD_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clear_i) |=> fnum_q == $past(load_val_i)); // R3
  AST_SYNTH_INCREMENT: assert property (@(posedge clk) disable iff (rst)
    (incr_i && !load_i && !clear_i) |=> fnum_q == fnum_t'($past(fnum_q) + 1'b1)); // R5
  AST_BUS_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> fnum_q == '0); // R11
endmodule

// File: rtl/sof_irq_flag.sv
module sof_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // Set has priority over a coincident write-one clear
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> flag_q == $past(flag_q)); // R9
endmodule

// File: rtl/sof_watchdog.sv
module sof_watchdog
  import sof_pkg::*;
#(
  parameter int FRAME_CYCLES = 125000,
  parameter int TOL_CYCLES   = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_reset_i,
  input  logic        sof_valid_i,
  input  logic [10:0] sof_fnum_i,
  input  logic        irq_clr_i,
  input  logic        irq_en_i,
  output logic        frame_strobe_o,
  output logic        synth_o,
  output logic        sof_flag_o,
  output logic        irq_o,
  output logic [10:0] fnum_o
);
  logic tick;
  logic armed;
  logic real_ev;
  logic any_ev;
  logic strobe_q;
  logic synth_q;

  assign real_ev = sof_valid_i && !bus_reset_i;
  assign any_ev  = real_ev || tick;

  sof_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .TOL_CYCLES  (TOL_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .bus_reset_i(bus_reset_i),
    .sof_valid_i(sof_valid_i),
    .tick_o     (tick),
    .armed_o    (armed)
  );

  sof_fnum_reg u_fnum (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (bus_reset_i),
    .load_i    (real_ev),
    .load_val_i(fnum_t'(sof_fnum_i)),
    .incr_i    (tick),
    .fnum_o    (fnum_o)
  );

  sof_irq_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (any_ev),
    .clr_i (irq_clr_i),
    .en_i  (irq_en_i),
    .flag_o(sof_flag_o),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      synth_q  <= 1'b0;
    end else begin
      strobe_q <= any_ev;
      synth_q  <= tick;
    end
  end

  assign frame_strobe_o = strobe_q;
  assign synth_o        = synth_q;

  AST_SYNTH_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !synth_q); // R2
  AST_SYNTH_IMPLIES_STROBE: assert property (@(posedge clk) disable iff (rst)
    synth_q |-> strobe_q); // R4
  AST_REAL_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    real_ev |=> !synth_q); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> sof_flag_o || $past(irq_clr_i)); // R8
endmodule

// File: tb/sof_watchdog_bench.sv
module sof_watchdog_bench;
  localparam int FRAME = 40;
  localparam int TOL   = 4;
  localparam int LIMIT = FRAME + TOL;

  typedef struct {
    logic [10:0] fn;
    logic        syn;
    int          cyc;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset_i = 1'b0;
  logic        sof_valid_i = 1'b0;
  logic [10:0] sof_fnum_i = '0;
  logic        irq_clr_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        frame_strobe_o, synth_o, sof_flag_o, irq_o;
  logic [10:0] fnum_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_cyc = 0;
  logic [10:0] last_fn = '0;
  ev_t exp_q[$];

  sof_watchdog #(.FRAME_CYCLES(FRAME), .TOL_CYCLES(TOL)) u_sof_watchdog (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .sof_valid_i(sof_valid_i),
    .sof_fnum_i(sof_fnum_i), .irq_clr_i(irq_clr_i), .irq_en_i(irq_en_i),
    .frame_strobe_o(frame_strobe_o), .synth_o(synth_o), .sof_flag_o(sof_flag_o),
    .irq_o(irq_o), .fnum_o(fnum_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops one expected event per observed strobe
  always @(negedge clk) begin
    if (!rst && frame_strobe_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2/R4: actual unexpected strobe fn %0d expected none (cycle %0d)", fnum_o, cyc);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        check("R3/R5/R6 frame number", int'(fnum_o), int'(e.fn));
        check("R4/R7 substitute flag", int'(synth_o), int'(e.syn));
        check("R4/R7 event cycle", cyc, e.cyc);
        check("R8 flag with strobe", int'(sof_flag_o), 1);
      end
    end
  end

  task automatic send_sof(input logic [10:0] f);
    sof_valid_i = 1'b1; sof_fnum_i = f;
    exp_q.push_back('{fn: f, syn: 1'b0, cyc: cyc + 1});
    last_cyc = cyc + 1; last_fn = f;
    @(negedge clk);
    sof_valid_i = 1'b0;
  endtask

  task automatic expect_synth(input int n);
    for (int i = 0; i < n; i++) begin
      last_cyc = last_cyc + LIMIT;
      last_fn  = last_fn + 11'd1;
      exp_q.push_back('{fn: last_fn, syn: 1'b1, cyc: last_cyc});
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 strobe", int'(frame_strobe_o), 0);
    check("R1 synth", int'(synth_o), 0);
    check("R1 flag", int'(sof_flag_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 fnum", int'(fnum_o), 0);

    // R2 idle until first marker: silence must produce nothing
    repeat (3 * LIMIT) @(negedge clk);
    check("R2 fnum idle", int'(fnum_o), 0);
    check("R2 flag idle", int'(sof_flag_o), 0);

    // R3 real marker, R4/R5 two substitutes
    send_sof(11'd100);
    check("R3 fnum loaded", int'(fnum_o), 100);
    expect_synth(2);
    wait_until(last_cyc + 1);
    check("R5 fnum after substitutes", int'(fnum_o), 102);

    // R10 gating
    irq_en_i = 1'b0; @(negedge clk);
    check("R10 irq gated off", int'(irq_o), 0);
    irq_en_i = 1'b1; @(negedge clk);
    check("R10 irq passes flag", int'(irq_o), 1);

    // R9 clear
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    check("R9 flag cleared", int'(sof_flag_o), 0);
    check("R10 irq follows clear", int'(irq_o), 0);

    // R6 wrap
    send_sof(11'd2047);
    expect_synth(1);
    wait_until(last_cyc + 1);
    check("R6 wrap to zero", int'(fnum_o), 0);

    // R9 clear coincident with substitute event: set wins
    begin
      int due;
      due = last_cyc + LIMIT;
      expect_synth(1);
      wait_until(due - 1);
      irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
      check("R9 set beats clear", int'(sof_flag_o), 1);
    end

    // R7 marker mid-interval restarts timer
    wait_until(last_cyc + 20);
    send_sof(11'd500);
    expect_synth(1);
    wait_until(last_cyc + 1);
    check("R7 restart then increment", int'(fnum_o), 501);

    // R7 marker exactly on timeout edge: real wins
    wait_until(last_cyc + LIMIT - 1);
    send_sof(11'd900);
    check("R7 loaded not incremented", int'(fnum_o), 900);
    expect_synth(1);
    wait_until(last_cyc + 1);
    check("R7 next substitute cadence", int'(fnum_o), 901);

    // R11 bus reset with coincident marker
    bus_reset_i = 1'b1; sof_valid_i = 1'b1; sof_fnum_i = 11'd33;
    @(negedge clk);
    bus_reset_i = 1'b0; sof_valid_i = 1'b0;
    check("R11 fnum zero", int'(fnum_o), 0);
    repeat (3 * LIMIT) @(negedge clk);
    check("R11 stays disarmed", int'(fnum_o), 0);

    // re-arm after bus reset
    send_sof(11'd7);
    expect_synth(1);
    wait_until(last_cyc + 2);

    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule